// File: doc/BRIEF.md
# Transmit Jabber Watchdog Controller

This block sits between a station's transmit path and the line driver of an Ethernet medium attachment unit. It measures how long the transmit-activity input stays asserted without a break. If one transmission outlasts the jabber limit, the block turns the driver enable off. A driver-fault input, such as a sensed output fault or an external cutoff that removes driver supply, also turns the driver off. The fault input is treated as a plain digital level.

Once the driver is off, it stays off as long as transmit activity or a fault is present. It is turned back on only after an unjab interval in which the transmit input has stayed idle and no fault has been seen. Any activity or fault during that interval starts the countdown again from zero. For the whole time the driver is off, the block raises a collision-request output so that collision signalling is sent toward the station.

Both intervals are counted in ticks of a 10 MHz timebase, which is divided down from the system clock. By default the jabber limit is 26 ms, which is 260000 ticks and lies within the allowed 20 to 35 ms. The unjab interval defaults to 400 ms, which is 4000000 ticks and lies within the allowed 340 to 500 ms. All three counts are parameters, so short values can be used in simulation.

Top module: `txjab_guard`

## Requirements
- R1: While reset is asserted and after it is released, `drv_en` is 1, `col_req` is 0 and both interval counters are cleared.
- R2: When `tx_active` stays high without a break for JAB_LIMIT timebase ticks, `drv_en` goes to 0. With fewer ticks than that, the driver stays enabled.
- R3: While the driver is disabled, `drv_en` stays 0 for as long as `tx_active` or `drv_fault` is high.
- R4: A low level on `tx_active` before the limit is reached clears the active-time count. Two bursts that are each shorter than the limit therefore never disable the driver.
- R5: `col_req` is 1 in exactly those cycles in which `drv_en` is 0, for the whole time the driver is disabled.
- R6: After a disable, `drv_en` returns to 1 only once UNJAB_LIMIT ticks have passed with `tx_active` and `drv_fault` both low. It does not return to 1 any earlier.
- R7: A cycle with `tx_active` or `drv_fault` high during the unjab countdown restarts that countdown from zero.
- R8: When `drv_fault` is high in a clock cycle, `drv_en` is 0 in the next cycle, even when no transmission is in progress.
- R9: The timebase produces one tick every CLK_DIV system clocks. Both interval counters advance only on ticks.
- R10: `tx_gated` equals `tx_active` while the driver is enabled, and it is 0 while the driver is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_active | input | 1 | Transmit activity from the station, synchronous to clk |
| drv_fault | input | 1 | Driver fault level, synchronous to clk |
| drv_en | output | 1 | Line-driver enable |
| tx_gated | output | 1 | Transmit activity passed to the driver |
| col_req | output | 1 | Request for collision signalling toward the station |

## Verification
The assertions check on every cycle the following rules. A fault disables the driver at the next edge. A disabled driver cannot come back on while activity or a fault is present. Re-enabling happens only after a quiet cycle. `col_req` is always the opposite of `drv_en`. Ticks are exactly CLK_DIV clocks apart. Only the bench scenarios can show how long the trip and unjab intervals actually last. They also show that short bursts never add up to a trip, and that a single-cycle pulse of activity or fault in the middle of the countdown pushes re-enabling back by a full interval.

// File: rtl/txjab_pkg.sv
package txjab_pkg;
  typedef enum logic [1:0] {
    ST_ARMED  = 2'd0,
    ST_JABBED = 2'd1,
    ST_UNJAB  = 2'd2
  } jab_state_e;
endpackage

// File: rtl/txjab_rst_sync.sv
module txjab_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= 2'b00;
    else        pipe_q <= {pipe_q[0], 1'b1};
  end

  assign rst_sn = pipe_q[1];
endmodule

// File: rtl/txjab_tick.sv
module txjab_tick #(
  parameter int CLK_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (CLK_DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(CLK_DIV);
      localparam logic [DW-1:0] LAST = DW'(CLK_DIV - 1);
      logic [DW-1:0] div_q, div_d;
      logic          wrap;

      assign wrap = (div_q == LAST);

      always_comb begin
        div_d = wrap ? '0 : div_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
      end

      assign tick = wrap;
    end
  endgenerate
endmodule

// File: rtl/txjab_span_cnt.sv
module txjab_span_cnt #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign hit    = step && !clr && (cnt_q == LAST);
  assign cnt_en = clr || step;

  always_comb begin
    if (clr || hit) cnt_d = '0;
    else            cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/txjab_fsm.sv
module txjab_fsm
  import txjab_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tx_active,
  input  logic drv_fault,
  input  logic act_hit,
  input  logic idle_hit,
  output logic in_armed,
  output logic in_unjab,
  output logic drv_en,
  output logic col_req
);
  jab_state_e st_q, st_d;
  logic       en_q, col_q;
  logic       busy;

  assign busy = tx_active || drv_fault;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_ARMED:  if (drv_fault || act_hit) st_d = ST_JABBED;
      ST_JABBED: if (!busy)                st_d = ST_UNJAB;
      ST_UNJAB: begin
        if (busy)          st_d = ST_JABBED;
        else if (idle_hit) st_d = ST_ARMED;
      end
      default:             st_d = ST_JABBED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_ARMED;
      en_q  <= 1'b1;
      col_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      en_q  <= (st_d == ST_ARMED);
      col_q <= (st_d != ST_ARMED);
    end
  end

  assign in_armed = (st_q == ST_ARMED);
  assign in_unjab = (st_q == ST_UNJAB);
  assign drv_en   = en_q;
  assign col_req  = col_q;
endmodule

// File: rtl/txjab_guard.sv
module txjab_guard #(
  parameter int CLK_DIV     = 10,
  parameter int JAB_LIMIT   = 260000,
  parameter int UNJAB_LIMIT = 4000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_active,
  input  logic drv_fault,
  output logic drv_en,
  output logic tx_gated,
  output logic col_req
);
  logic rst_sn;
  logic tick;
  logic in_armed, in_unjab;
  logic act_hit, idle_hit;
  logic act_clr, idle_clr;

  txjab_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  txjab_tick #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_sn),
    .tick  (tick)
  );

  assign act_clr  = !in_armed || !tx_active;
  assign idle_clr = !in_unjab || tx_active || drv_fault;

  txjab_span_cnt #(.LIMIT(JAB_LIMIT)) u_act_cnt (
    .clk   (clk),
    .rst_n (rst_sn),
    .clr   (act_clr),
    .step  (tick),
    .hit   (act_hit)
  );

  txjab_span_cnt #(.LIMIT(UNJAB_LIMIT)) u_idle_cnt (
    .clk   (clk),
    .rst_n (rst_sn),
    .clr   (idle_clr),
    .step  (tick),
    .hit   (idle_hit)
  );

  txjab_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_sn),
    .tx_active (tx_active),
    .drv_fault (drv_fault),
    .act_hit   (act_hit),
    .idle_hit  (idle_hit),
    .in_armed  (in_armed),
    .in_unjab  (in_unjab),
    .drv_en    (drv_en),
    .col_req   (col_req)
  );

  assign tx_gated = tx_active && drv_en;
endmodule

// File: rtl/txjab_guard_chk.sv
module txjab_guard_chk #(
  parameter int CLK_DIV = 10
) (
  input logic clk,
  input logic rst_sn,
  input logic tx_active,
  input logic drv_fault,
  input logic drv_en,
  input logic col_req,
  input logic tick
);
  localparam int GW = $clog2(CLK_DIV + 1);
  localparam logic [GW-1:0] GAP = GW'(CLK_DIV - 1);
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)   gap_q <= '0;
    else if (tick) gap_q <= '0;
    else           gap_q <= gap_q + 1'b1;
  end

  a_r9_tick_spacing: assert property (@(posedge clk) disable iff (!rst_sn)
    tick |-> (gap_q == GAP));

  a_r8_fault_cuts: assert property (@(posedge clk) disable iff (!rst_sn)
    drv_fault |=> !drv_en);

  a_r3_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_sn)
    (!drv_en && (tx_active || drv_fault)) |=> !drv_en);

  a_r6_reenable_after_quiet: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(drv_en) |-> $past(!tx_active && !drv_fault));

  a_r5_flag_opposes_enable: assert property (@(posedge clk) disable iff (!rst_sn)
    col_req != drv_en);

  a_r2_trip_has_cause: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(drv_en) |-> $past(tx_active || drv_fault));
endmodule

bind txjab_guard txjab_guard_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk       (clk),
  .rst_sn    (rst_sn),
  .tx_active (tx_active),
  .drv_fault (drv_fault),
  .drv_en    (drv_en),
  .col_req   (col_req),
  .tick      (tick)
);

// File: tb/sim_txjab_guard.sv
module sim_txjab_guard;
  localparam int D = 4;
  localparam int J = 10;
  localparam int U = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_active = 1'b0;
  logic drv_fault = 1'b0;
  logic drv_en, tx_gated, col_req;

  typedef struct {
    int    due;
    logic  en;
    logic  col;
    logic  gat;
    string req;
  } exp_t;

  exp_t sb[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;

  always #5 clk = ~clk;

  txjab_guard #(.CLK_DIV(D), .JAB_LIMIT(J), .UNJAB_LIMIT(U)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_active (tx_active),
    .drv_fault (drv_fault),
    .drv_en    (drv_en),
    .tx_gated  (tx_gated),
    .col_req   (col_req)
  );

  function automatic void compare(exp_t e);
    n_chk++;
    if (drv_en !== e.en || col_req !== e.col || tx_gated !== e.gat) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: en/col/gated=%b%b%b expected %b%b%b",
               e.req, cyc, drv_en, col_req, tx_gated, e.en, e.col, e.gat);
    end
  endfunction

  function automatic void expect_in(int dly, logic en, logic col, logic gat, string req);
    exp_t e;
    e.due = cyc + dly; e.en = en; e.col = col; e.gat = gat; e.req = req;
    sb.push_back(e);
  endfunction

  function automatic void chk_now(logic en, logic col, logic gat, string req);
    exp_t e;
    e.due = cyc; e.en = en; e.col = col; e.gat = gat; e.req = req;
    compare(e);
  endfunction

  // monitor: pops scoreboard items as their cycle comes due
  initial begin
    forever begin
      @(posedge clk);
      #2;
      cyc++;
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].due == cyc) begin
          compare(sb[i]);
          sb.delete(i);
        end
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic trip_and_drop();
    tx_active = 1'b1;
    idle(J * D + 2);
    tx_active = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(3);
    chk_now(1'b1, 1'b0, 1'b0, "R1 during reset");
    rst_n = 1'b1;
    idle(4);
    chk_now(1'b1, 1'b0, 1'b0, "R1 after reset");

    // R4: two sub-limit bursts
    tx_active = 1'b1;
    expect_in((J - 1) * D, 1'b1, 1'b0, 1'b1, "R4 first burst");
    idle((J - 1) * D);
    tx_active = 1'b0;
    idle(3);
    tx_active = 1'b1;
    expect_in((J - 1) * D, 1'b1, 1'b0, 1'b1, "R4 second burst");
    idle((J - 1) * D);
    tx_active = 1'b0;
    idle(3);

    // R2 R9: trip timing, R3 hold, R5 flag
    tx_active = 1'b1;
    expect_in((J - 1) * D, 1'b1, 1'b0, 1'b1, "R2 R9 below limit");
    expect_in(J * D + 2, 1'b0, 1'b1, 1'b0, "R2 R9 trip at limit");
    idle(J * D + 2);
    expect_in(40, 1'b0, 1'b1, 1'b0, "R3 held by activity");
    idle(40);
    tx_active = 1'b0;

    // R6 unjab timing
    expect_in(1, 1'b0, 1'b1, 1'b0, "R5 flag during unjab");
    expect_in((U - 1) * D, 1'b0, 1'b1, 1'b0, "R6 too early");
    expect_in(U * D + 2, 1'b1, 1'b0, 1'b0, "R6 reenabled");
    idle(U * D + 2);

    // R10 gating while enabled
    tx_active = 1'b1;
    expect_in(1, 1'b1, 1'b0, 1'b1, "R10 pass through");
    idle(2);
    tx_active = 1'b0;
    idle(2);
    chk_now(1'b1, 1'b0, 1'b0, "R10 idle");

    // R7: activity pulse restarts countdown
    trip_and_drop();
    idle(10 * D);
    tx_active = 1'b1;
    idle(1);
    tx_active = 1'b0;
    expect_in((U - 1) * D, 1'b0, 1'b1, 1'b0, "R7 activity restart");
    expect_in(U * D + 2, 1'b1, 1'b0, 1'b0, "R7 after activity restart");
    idle(U * D + 2);

    // R7: fault pulse restarts countdown
    trip_and_drop();
    idle(10 * D);
    drv_fault = 1'b1;
    idle(1);
    drv_fault = 1'b0;
    expect_in((U - 1) * D, 1'b0, 1'b1, 1'b0, "R7 fault restart");
    expect_in(U * D + 2, 1'b1, 1'b0, 1'b0, "R7 after fault restart");
    idle(U * D + 2);

    // R8: fault with no transmission
    drv_fault = 1'b1;
    expect_in(1, 1'b0, 1'b1, 1'b0, "R8 fault cuts driver");
    idle(30);
    chk_now(1'b0, 1'b1, 1'b0, "R3 held by fault");
    tx_active = 1'b1;
    idle(1);
    chk_now(1'b0, 1'b1, 1'b0, "R10 blocked while disabled");
    tx_active = 1'b0;
    drv_fault = 1'b0;
    expect_in((U - 1) * D, 1'b0, 1'b1, 1'b0, "R6 fault too early");
    expect_in(U * D + 2, 1'b1, 1'b0, 1'b0, "R8 recovery");
    idle(U * D + 2);

    while (sb.size() != 0) @(negedge clk);
    idle(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule